// File: doc/BRIEF.md
# Three-Wire Serial Register Bus Slave

This block is the target end of a three-pin serial link. The pins are an active-low select, a serial clock and one data line that both ends share. Every transfer begins with a 9-bit header that names one of eight attached register-file devices, a read or write direction and one of 32 register slots. A 16-bit value phase follows the header. The block oversamples all three pins with its own system clock and finds the serial clock's rising edges itself. It turns each header into a one-cycle strobe on a plain parallel access port.

On a write, the block collects the 16 value bits and delivers them to the device after the last bit has arrived. On a read, it asks the device for the value as soon as the header is complete, before any value bit moves. It then turns the data line around and shifts the value out. After a value phase the block is ready for another header at once, so a host can chain transfers without toggling select. A header that names a device slot with nothing attached produces no access. It sets a sticky error flag instead.

Top module: `tsb_slave`

## Requirements
- R1: While select is high, the block is in state IDLE. The data-line enable and both strobes are low, and the next transfer starts with a fresh header. Raising select part-way through a transfer abandons it. Reset leaves select seen as high and the serial clock and data seen as low.
- R2: Data bits are taken only on rising edges of the serial clock that occur while select is low, most significant bit first. Clock pulses while select is high cause no strobe and no drive.
- R3: Header bits [8:6] give the device number on `acc_dev`. Bit 5 is the direction (1 = read, 0 = write). Bits [4:0] give the register slot on `acc_reg`.
- R4: On a read to an attached device, `acc_rd` pulses for one cycle after the 9th header edge and before the first value edge, and `acc_rdata` is taken in that cycle. The 16-bit value is then driven MSB first on `bus_dout`, with a new bit at each rising edge, while `bus_doe` is high.
- R5: On a write to an attached device, the 16 value bits are collected MSB first. A single `acc_wr` pulse with the complete word on `acc_wdata` follows only the 16th value edge. No strobe occurs earlier.
- R6: After a value phase the block is back in header mode. On a read, `bus_doe` drops at the falling edge that follows the 16th rising edge. A new header is accepted without a select toggle.
- R7: A header naming a device whose bit in `DEV_MASK` is clear produces no strobe and never drives the data line. It sets `bus_err`, which stays set until reset. The 16 value bits are consumed and the following header is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel_n | input | 1 | Serial select, active low |
| bus_clk | input | 1 | Serial clock from the host |
| bus_din | input | 1 | Serial data line, input side |
| bus_dout | output | 1 | Serial data line, output side |
| bus_doe | output | 1 | Drive enable for the data line |
| acc_dev | output | 3 | Device number of the current access |
| acc_reg | output | 5 | Register slot of the current access |
| acc_rd | output | 1 | One-cycle read strobe |
| acc_wr | output | 1 | One-cycle write strobe |
| acc_wdata | output | 16 | Write word, valid with `acc_wr` |
| acc_rdata | input | 16 | Read word from the device, taken while `acc_rd` is high |
| bus_err | output | 1 | Sticky flag: header named an absent device |

## Verification
The bench sweeps every device number against low, middle and top register slots, writing and reading each one. It watches for the strobe that comes one edge too early, before the 16th write bit or after the first read bit, which would hand the device a shifted or partial word. Transfers chained without a select toggle and a select raised part-way through a header catch a bit counter that is not reloaded, which would misframe every later transfer. Accesses to absent devices check that a design which let them through would show up as a stray strobe, a driven data line or a missing or self-clearing error flag.

// File: rtl/tsb_pkg.sv
package tsb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_FETCH,
        ST_RDATA,
        ST_TAIL,
        ST_WDATA,
        ST_COMMIT,
        ST_SKIP
    } tsb_state_e;

    typedef enum logic [2:0] {
        SH_HOLD,
        SH_SHIFT,
        SH_LOAD,
        SH_ARM_VAL,
        SH_ARM_HDR
    } tsb_op_e;

endpackage

// File: rtl/tsb_sync.sv
module tsb_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/tsb_shifter.sv
module tsb_shifter
    import tsb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int HDR_W  = 9,
    localparam int MAX_W = (DATA_W > HDR_W) ? DATA_W : HDR_W,
    localparam int CNT_W = $clog2(MAX_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tsb_op_e           op,
    input  logic              din,
    input  logic [DATA_W-1:0] par_in,
    output logic [DATA_W-1:0] shreg,
    output logic              cnt_zero
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= CNT_W'(HDR_W - 1);
        end else begin
            unique case (op)
                SH_HOLD: ;
                SH_SHIFT: begin
                    shreg <= {shreg[DATA_W-2:0], din};
                    cnt   <= cnt - 1'b1;
                end
                SH_LOAD: begin
                    shreg <= par_in;
                    cnt   <= CNT_W'(DATA_W - 1);
                end
                SH_ARM_VAL: begin
                    shreg <= '0;
                    cnt   <= CNT_W'(DATA_W - 1);
                end
                SH_ARM_HDR: begin
                    shreg <= '0;
                    cnt   <= CNT_W'(HDR_W - 1);
                end
                default: ;
            endcase
        end
    end

    assign cnt_zero = (cnt == '0);
endmodule

// File: rtl/tsb_ctrl.sv
module tsb_ctrl
    import tsb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    sel_hi,
    input  logic    rise,
    input  logic    fall,
    input  logic    cnt_zero,
    input  logic    hdr_rd,
    input  logic    dev_ok,
    output tsb_op_e op,
    output logic    hdr_done,
    output logic    err_set,
    output logic    acc_rd,
    output logic    acc_wr,
    output logic    drive
);
    tsb_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt      = state;
        op       = SH_HOLD;
        hdr_done = 1'b0;
        err_set  = 1'b0;
        if (sel_hi) begin
            nxt = ST_IDLE;
            op  = SH_ARM_HDR;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    op  = SH_ARM_HDR;
                    nxt = ST_HDR;
                end
                ST_HDR: begin
                    if (rise) begin
                        if (cnt_zero) begin
                            hdr_done = 1'b1;
                            op       = SH_ARM_VAL;
                            if (!dev_ok) begin
                                err_set = 1'b1;
                                nxt     = ST_SKIP;
                            end else if (hdr_rd) begin
                                nxt = ST_FETCH;
                            end else begin
                                nxt = ST_WDATA;
                            end
                        end else begin
                            op = SH_SHIFT;
                        end
                    end
                end
                ST_FETCH: begin
                    op  = SH_LOAD;
                    nxt = ST_RDATA;
                end
                ST_RDATA: begin
                    if (rise) begin
                        op = SH_SHIFT;
                        if (cnt_zero) nxt = ST_TAIL;
                    end
                end
                ST_TAIL: begin
                    if (fall) begin
                        op  = SH_ARM_HDR;
                        nxt = ST_HDR;
                    end
                end
                ST_WDATA: begin
                    if (rise) begin
                        op = SH_SHIFT;
                        if (cnt_zero) nxt = ST_COMMIT;
                    end
                end
                ST_COMMIT: begin
                    op  = SH_ARM_HDR;
                    nxt = ST_HDR;
                end
                ST_SKIP: begin
                    if (rise) begin
                        if (cnt_zero) begin
                            op  = SH_ARM_HDR;
                            nxt = ST_HDR;
                        end else begin
                            op = SH_SHIFT;
                        end
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        acc_rd = (state == ST_FETCH);
        acc_wr = (state == ST_COMMIT);
        drive  = (state == ST_RDATA) || (state == ST_TAIL);
    end
endmodule

// File: rtl/tsb_slave.sv
module tsb_slave
    import tsb_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int REG_W       = 5,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2,
    parameter logic [(1<<ADDR_W)-1:0] DEV_MASK = 'h06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_n,
    input  logic              bus_clk,
    input  logic              bus_din,
    output logic              bus_dout,
    output logic              bus_doe,
    output logic [ADDR_W-1:0] acc_dev,
    output logic [REG_W-1:0]  acc_reg,
    output logic              acc_rd,
    output logic              acc_wr,
    output logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] acc_rdata,
    output logic              bus_err
);
    localparam int HDR_W = ADDR_W + 1 + REG_W;

    logic s_sel, s_clk, s_din, clk_q;
    logic rise, fall;

    tsb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bus_sel_n, bus_clk, bus_din}),
        .q     ({s_sel, s_clk, s_din})
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clk_q <= 1'b0;
        else        clk_q <= s_clk;
    end

    assign rise = s_clk & ~clk_q & ~s_sel;
    assign fall = ~s_clk & clk_q;

    tsb_op_e           op;
    logic [DATA_W-1:0] shreg;
    logic              cnt_zero;

    tsb_shifter #(.DATA_W(DATA_W), .HDR_W(HDR_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .op       (op),
        .din      (s_din),
        .par_in   (acc_rdata),
        .shreg    (shreg),
        .cnt_zero (cnt_zero)
    );

    logic [HDR_W-1:0]  hdr_word;
    logic [ADDR_W-1:0] hdr_dev;
    logic [REG_W-1:0]  hdr_reg;
    logic              hdr_rd;
    logic              dev_ok;

    assign hdr_word = {shreg[HDR_W-2:0], s_din};
    assign hdr_dev  = hdr_word[HDR_W-1 -: ADDR_W];
    assign hdr_rd   = hdr_word[REG_W];
    assign hdr_reg  = hdr_word[REG_W-1:0];
    assign dev_ok   = DEV_MASK[hdr_dev];

    logic hdr_done, err_set, drive;

    tsb_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_hi   (s_sel),
        .rise     (rise),
        .fall     (fall),
        .cnt_zero (cnt_zero),
        .hdr_rd   (hdr_rd),
        .dev_ok   (dev_ok),
        .op       (op),
        .hdr_done (hdr_done),
        .err_set  (err_set),
        .acc_rd   (acc_rd),
        .acc_wr   (acc_wr),
        .drive    (drive)
    );

    logic [ADDR_W-1:0] dev_q;
    logic [REG_W-1:0]  reg_q;
    logic              dout_q, err_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_q  <= '0;
            reg_q  <= '0;
            dout_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            if (hdr_done) begin
                dev_q <= hdr_dev;
                reg_q <= hdr_reg;
            end
            if (drive && rise) dout_q <= shreg[DATA_W-1];
            if (err_set)       err_q  <= 1'b1;
        end
    end

    assign acc_dev   = dev_q;
    assign acc_reg   = reg_q;
    assign acc_wdata = shreg;
    assign bus_doe   = drive;
    assign bus_dout  = drive & dout_q;
    assign bus_err   = err_q;
endmodule

// File: rtl/tsb_slave_chk.sv
module tsb_slave_chk #(
    parameter int ADDR_W = 3,
    parameter logic [(1<<ADDR_W)-1:0] DEV_MASK = '1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_sync,
    input logic              bus_doe,
    input logic              acc_rd,
    input logic              acc_wr,
    input logic [ADDR_W-1:0] acc_dev,
    input logic              bus_err
);
    // R1: a synchronized high select silences the bus side next cycle
    a_r1_sel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sel_sync |=> (!bus_doe && !acc_rd && !acc_wr));

    // R4: the drive window only opens right after a device fetch
    a_r4_oe_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_doe) |-> $past(acc_rd));

    a_r4_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> !acc_rd);

    a_r5_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> !acc_wr);

    a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_rd && acc_wr));

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> bus_err);

    a_r7_only_present: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd || acc_wr) |-> DEV_MASK[acc_dev]);
endmodule

bind tsb_slave tsb_slave_chk #(.ADDR_W(ADDR_W), .DEV_MASK(DEV_MASK)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_sync (s_sel),
    .bus_doe  (bus_doe),
    .acc_rd   (acc_rd),
    .acc_wr   (acc_wr),
    .acc_dev  (acc_dev),
    .bus_err  (bus_err)
);

// File: tb/test_tsb_slave.sv
module test_tsb_slave;
    localparam int HALF = 6;
    localparam logic [7:0] MASK = 8'hA6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        sel_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
    logic        bus_dout, bus_doe, acc_rd, acc_wr, bus_err;
    logic [2:0]  acc_dev;
    logic [4:0]  acc_reg;
    logic [15:0] acc_wdata, acc_rdata;

    function automatic logic [15:0] dev_word(logic [2:0] d, logic [4:0] r);
        return ({r, d, 3'b101, r} ^ 16'h3C5A) + {13'b0, d};
    endfunction

    assign acc_rdata = dev_word(acc_dev, acc_reg);

    tsb_slave #(.DEV_MASK(MASK)) i_tsb_slave (
        .clk(clk), .rst_n(rst_n),
        .bus_sel_n(sel_n), .bus_clk(sclk), .bus_din(sdin),
        .bus_dout(bus_dout), .bus_doe(bus_doe),
        .acc_dev(acc_dev), .acc_reg(acc_reg),
        .acc_rd(acc_rd), .acc_wr(acc_wr),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
        .bus_err(bus_err)
    );

    int checks = 0, fails = 0;
    int rd_cnt = 0, wr_cnt = 0;
    logic [2:0]  cap_dev = '0;
    logic [4:0]  cap_reg = '0;
    logic [15:0] cap_wdata = '0;
    bit doe_seen = 0;

    always @(negedge clk) begin
        if (acc_rd) begin rd_cnt++; cap_dev = acc_dev; cap_reg = acc_reg; end
        if (acc_wr) begin wr_cnt++; cap_dev = acc_dev; cap_reg = acc_reg; cap_wdata = acc_wdata; end
        if (bus_doe) doe_seen = 1;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_bit(input logic b, output logic got);
        sdin = b;
        wait_cyc(HALF);
        sclk = 1'b1;
        wait_cyc(HALF);
        got = bus_dout;
        sclk = 1'b0;
    endtask

    task automatic send_hdr(input logic [2:0] d, input logic rd, input logic [4:0] r, input int nbits);
        logic [8:0] w;
        logic g;
        w = {d, rd, r};
        for (int i = 8; i > 8 - nbits; i--) bus_bit(w[i], g);
    endtask

    task automatic do_write(input logic [2:0] d, input logic [4:0] r, input logic [15:0] v);
        int wc0, rc0;
        logic g;
        wc0 = wr_cnt; rc0 = rd_cnt;
        send_hdr(d, 1'b0, r, 9);
        for (int i = 15; i >= 0; i--) begin
            if (i == 0) check("R5 no strobe before last bit", wr_cnt, wc0);
            bus_bit(v[i], g);
        end
        wait_cyc(HALF);
        check("R6 no drive after write", bus_doe, 0);
        check("R2 no read strobe on write", rd_cnt, rc0);
        if (MASK[d]) begin
            check("R5 single write strobe", wr_cnt, wc0 + 1);
            check("R3 write device", cap_dev, d);
            check("R3 write register", cap_reg, r);
            check("R5 write word", cap_wdata, v);
        end else begin
            check("R7 no write strobe absent", wr_cnt, wc0);
            check("R7 error set", bus_err, 1);
        end
    endtask

    task automatic do_read(input logic [2:0] d, input logic [4:0] r);
        int rc0, wc0;
        logic [15:0] got;
        logic g;
        rc0 = rd_cnt; wc0 = wr_cnt;
        send_hdr(d, 1'b1, r, 9);
        if (MASK[d]) begin
            check("R4 fetch before data bits", rd_cnt, rc0 + 1);
            check("R3 read device", cap_dev, d);
            check("R3 read register", cap_reg, r);
            check("R4 drive enabled", bus_doe, 1);
        end
        for (int i = 15; i >= 0; i--) begin
            bus_bit(1'b0, g);
            got[i] = g;
        end
        wait_cyc(HALF);
        check("R6 drive released", bus_doe, 0);
        check("R2 no write strobe on read", wr_cnt, wc0);
        if (MASK[d]) begin
            check("R4 read word", got, dev_word(d, r));
        end else begin
            check("R7 no read strobe absent", rd_cnt, rc0);
            check("R7 absent reads zero", got, 0);
            check("R7 error set", bus_err, 1);
        end
    endtask

    task automatic sel_low();
        sel_n = 1'b0; wait_cyc(HALF);
    endtask

    task automatic sel_high();
        sel_n = 1'b1; wait_cyc(HALF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic g;
        wait_cyc(5);
        check("R1 reset doe", bus_doe, 0);
        check("R1 reset dout", bus_dout, 0);
        check("R1 reset err", bus_err, 0);
        check("R1 reset strobes", {acc_rd, acc_wr}, 0);
        rst_n = 1'b1;
        wait_cyc(5);

        // R2: clocking with select high does nothing
        for (int i = 0; i < 25; i++) bus_bit(1'b1, g);
        wait_cyc(HALF);
        check("R2 sel high no strobe", rd_cnt + wr_cnt, 0);
        check("R2 sel high no drive", doe_seen, 0);

        // sweep all present devices
        for (int d = 0; d < 8; d++) begin
            if (MASK[d]) begin
                for (int k = 0; k < 3; k++) begin
                    logic [4:0] r;
                    r = (k == 0) ? 5'd0 : (k == 1) ? 5'd10 : 5'd31;
                    sel_low();
                    do_write(3'(d), r, 16'hA5C3 ^ {3'(d), r, 3'(d), r});
                    do_read(3'(d), r);
                    sel_high();
                end
            end
        end
        check("R7 no error for present devices", bus_err, 0);

        // R6: chained transfers under one select
        sel_low();
        do_write(3'd1, 5'd3, 16'h8001);
        do_write(3'd2, 5'd4, 16'h7FFE);
        do_read(3'd5, 5'd6);
        do_read(3'd7, 5'd21);
        sel_high();

        // R1: abort part-way through a header
        sel_low();
        send_hdr(3'd7, 1'b1, 5'd9, 5);
        sel_high();
        sel_low();
        do_write(3'd2, 5'd17, 16'hBEEF);
        sel_high();

        // R7: absent devices
        doe_seen = 0;
        for (int d = 0; d < 8; d++) begin
            if (!MASK[d]) begin
                sel_low();
                do_write(3'(d), 5'd2, 16'hFFFF);
                do_read(3'(d), 5'd2);
                sel_high();
            end
        end
        check("R7 absent never drives", doe_seen, 0);
        sel_low();
        do_read(3'd1, 5'd12);
        sel_high();
        check("R7 error remains set", bus_err, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule